// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit carries out the one-bit instructions of an 8-bit controller core. The carry flag serves as a one-bit accumulator. An 8-bit bit address is folded into a byte address plus a bit index. The byte that holds the bit is read over a byte-wide RAM/SFR port, and when the operation changes the bit, the byte is written back with only that bit changed. Computing a branch target is left to the sequencer. The unit reports only whether a bit-test branch is taken.

The core starts an operation by pulsing `start_i` with an opcode, a bit address and the current carry. Operations that touch only the carry finish in one cycle and never use the memory port. Operations that read a bit and change only carry or branch state take two cycles. Operations that change a bit take three cycles. While an operation is running, `busy_o` is high and any new start is ignored. A new operation may start in the same cycle that `done_o` reports the previous one.

Top module: `bool_bit_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `carry_upd_o`, `taken_o`, `mem_re_o`, `mem_we_o` and `mem_rmw_o` are all low.
- R2: Bit addresses 0x00 to 0x7F select byte 0x20 plus (address / 8), bit (address mod 8). For example, 0x17 selects byte 0x22 bit 7, 0x7F selects byte 0x2F bit 7, and 0x00 selects byte 0x20 bit 0.
- R3: Bit addresses 0x80 to 0xFF select the byte at the address with its low three bits cleared, bit (address mod 8). For example, 0xD3 selects byte 0xD0 bit 3.
- R4: `op_i` codes are as follows. 0 sets carry, 1 clears carry, 2 inverts carry, and 15 does nothing. All four finish with `done_o` one cycle after acceptance and make no memory access. Codes 0 to 2 raise `carry_upd_o`.
- R5: Codes 3 (set bit), 4 (clear bit), 5 (invert bit) and 11 (store carry into bit) take a read cycle, then a write cycle. `done_o` comes three cycles after acceptance. The written byte differs from the read byte in the target bit at most.
- R6: Codes 6 and 7 AND the carry with the bit or with its inverse. Codes 8 and 9 OR the carry with the bit or with its inverse. The result appears on `carry_o` with `carry_upd_o`. There is no write, and `done_o` comes two cycles after acceptance.
- R7: Code 10 loads the addressed bit into the carry in two cycles, with no write.
- R8: Code 12 raises `taken_o` when the bit is 1, and code 13 raises it when the bit is 0. Neither writes memory, and `done_o` comes two cycles after acceptance.
- R9: Code 14 raises `taken_o` when the bit is 1 and then clears that bit with a write, finishing in three cycles. When the bit is 0, it does not branch, does not write, and finishes in two cycles.
- R10: Reads made by codes 3, 4, 5, 11 and 14 assert `mem_rmw_o`, so that a port register returns its output latch rather than its pin level. Reads by all other codes keep `mem_rmw_o` low.
- R11: `start_i` is ignored while `busy_o` is high. A start in the cycle that `done_o` is high is accepted.
- R12: `carry_upd_o` and `taken_o` are high only together with `done_o`. `carry_upd_o` stays low for codes that do not write the carry. `taken_o` stays low for codes other than 12 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (taken when idle) |
| op_i | input | 4 | Operation code |
| bit_addr_i | input | 8 | Bit address |
| carry_i | input | 1 | Carry flag at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | New carry value |
| carry_upd_o | output | 1 | `carry_o` is to be written to the flag |
| taken_o | output | 1 | Bit-test branch taken |
| mem_addr_o | output | 8 | RAM/SFR byte address |
| mem_re_o | output | 1 | Read strobe; data is expected on `mem_rdata_i` in the same cycle |
| mem_rmw_o | output | 1 | Read is for modify; return the port latch |
| mem_rdata_i | input | 8 | Read data |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |

## Verification
Two events can fall in the same cycle: one operation completing and the next one being accepted. The driver asserts each new start as soon as `busy_o` is low, and that happens in the cycle of `done_o`. As a result, a set or clear is followed directly by a read of the same byte, and the scoreboard judges the reused byte against its own model. The bench also raises `start_i` in the middle of a write sequence. It then checks that no extra completion appears and that the byte the intruding start named is unchanged.

// File: rtl/bool_bit_pkg.sv
package bool_bit_pkg;

  typedef enum logic [3:0] {
    OP_SETC    = 4'd0,
    OP_CLRC    = 4'd1,
    OP_CPLC    = 4'd2,
    OP_SETB    = 4'd3,
    OP_CLRB    = 4'd4,
    OP_CPLB    = 4'd5,
    OP_ANDC    = 4'd6,
    OP_ANDNC   = 4'd7,
    OP_ORC     = 4'd8,
    OP_ORNC    = 4'd9,
    OP_LDC     = 4'd10,
    OP_STC     = 4'd11,
    OP_JSET    = 4'd12,
    OP_JCLR    = 4'd13,
    OP_JSETCLR = 4'd14,
    OP_NONE    = 4'd15
  } bit_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  function automatic logic op_uses_mem(bit_op_e op);
    return (op >= OP_SETB) && (op <= OP_JSETCLR);
  endfunction

  function automatic logic op_is_rmw(bit_op_e op);
    return (op == OP_SETB) || (op == OP_CLRB) || (op == OP_CPLB) ||
           (op == OP_STC)  || (op == OP_JSETCLR);
  endfunction

endpackage

// File: rtl/bool_addr_map.sv
module bool_addr_map #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
  localparam int unsigned IDX_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [IDX_W-1:0]  bit_idx_o
);

  localparam logic [ADDR_W-1:0] RAM_SPAN = ADDR_W'(1) << (ADDR_W - 1 - IDX_W);

  always_comb begin
    bit_idx_o = bit_addr_i[IDX_W-1:0];
    if (!bit_addr_i[ADDR_W-1]) begin
      byte_addr_o = RAM_BASE + (bit_addr_i >> IDX_W);
    end else begin
      byte_addr_o = {bit_addr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    end
  end

  assert_ram_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_addr_i[ADDR_W-1]) |->
      ((byte_addr_o >= RAM_BASE) && (byte_addr_o < RAM_BASE + RAM_SPAN)));

  assert_sfr_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_addr_i[ADDR_W-1]) |->
      (byte_addr_o[ADDR_W-1] && (byte_addr_o[IDX_W-1:0] == '0)));

endmodule

// File: rtl/bool_bit_alu.sv
module bool_bit_alu
  import bool_bit_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = $clog2(BYTE_W)
) (
  input  bit_op_e           op_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              carry_o,
  output logic              carry_upd_o,
  output logic              taken_o,
  output logic              wr_o
);

  logic bit_v;

  always_comb begin
    bit_v       = byte_i[idx_i];
    byte_o      = byte_i;
    carry_o     = carry_i;
    carry_upd_o = 1'b0;
    taken_o     = 1'b0;
    wr_o        = 1'b0;
    unique case (op_i)
      OP_SETC:    begin carry_o = 1'b1;              carry_upd_o = 1'b1; end
      OP_CLRC:    begin carry_o = 1'b0;              carry_upd_o = 1'b1; end
      OP_CPLC:    begin carry_o = ~carry_i;          carry_upd_o = 1'b1; end
      OP_SETB:    begin byte_o[idx_i] = 1'b1;        wr_o = 1'b1; end
      OP_CLRB:    begin byte_o[idx_i] = 1'b0;        wr_o = 1'b1; end
      OP_CPLB:    begin byte_o[idx_i] = ~bit_v;      wr_o = 1'b1; end
      OP_ANDC:    begin carry_o = carry_i & bit_v;   carry_upd_o = 1'b1; end
      OP_ANDNC:   begin carry_o = carry_i & ~bit_v;  carry_upd_o = 1'b1; end
      OP_ORC:     begin carry_o = carry_i | bit_v;   carry_upd_o = 1'b1; end
      OP_ORNC:    begin carry_o = carry_i | ~bit_v;  carry_upd_o = 1'b1; end
      OP_LDC:     begin carry_o = bit_v;             carry_upd_o = 1'b1; end
      OP_STC:     begin byte_o[idx_i] = carry_i;     wr_o = 1'b1; end
      OP_JSET:    taken_o = bit_v;
      OP_JCLR:    taken_o = ~bit_v;
      OP_JSETCLR: begin taken_o = bit_v; wr_o = bit_v; byte_o[idx_i] = 1'b0; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/bool_bit_unit.sv
module bool_bit_unit
  import bool_bit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic              carry_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              carry_upd_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_rmw_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o
);

  localparam int unsigned IDX_W = $clog2(BYTE_W);

  seq_state_e        state_q;
  bit_op_e           op_q, op_in, alu_op;
  logic [ADDR_W-1:0] addr_q;
  logic              cin_q, alu_cin;
  logic [BYTE_W-1:0] wbyte_q, rbyte_q;
  logic              done_q, carry_q, upd_q, taken_q, tk_hold_q;
  logic              idle, accept;

  logic [ADDR_W-1:0] byte_addr;
  logic [IDX_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] alu_byte;
  logic              alu_carry, alu_upd, alu_taken, alu_wr;

  assign op_in  = bit_op_e'(op_i);
  assign idle   = (state_q == ST_IDLE);
  assign accept = start_i && idle;
  // carry-only ops resolve straight from the inputs while idle
  assign alu_op  = idle ? op_in   : op_q;
  assign alu_cin = idle ? carry_i : cin_q;

  bool_addr_map #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .RAM_BASE(RAM_BASE)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (mem_re_o),
    .bit_addr_i  (addr_q),
    .byte_addr_o (byte_addr),
    .bit_idx_o   (bit_idx)
  );

  bool_bit_alu #(.BYTE_W(BYTE_W)) u_alu (
    .op_i        (alu_op),
    .byte_i      (mem_rdata_i),
    .idx_i       (bit_idx),
    .carry_i     (alu_cin),
    .byte_o      (alu_byte),
    .carry_o     (alu_carry),
    .carry_upd_o (alu_upd),
    .taken_o     (alu_taken),
    .wr_o        (alu_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      addr_q    <= '0;
      cin_q     <= 1'b0;
      wbyte_q   <= '0;
      rbyte_q   <= '0;
      done_q    <= 1'b0;
      carry_q   <= 1'b0;
      upd_q     <= 1'b0;
      taken_q   <= 1'b0;
      tk_hold_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      upd_q   <= 1'b0;
      taken_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q   <= op_in;
          addr_q <= bit_addr_i;
          cin_q  <= carry_i;
          if (op_uses_mem(op_in)) begin
            state_q <= ST_READ;
          end else begin
            done_q  <= 1'b1;
            upd_q   <= alu_upd;
            carry_q <= alu_carry;
          end
        end
        ST_READ: begin
          rbyte_q   <= mem_rdata_i;
          wbyte_q   <= alu_byte;
          tk_hold_q <= alu_taken;
          if (alu_wr) begin
            state_q <= ST_WRITE;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            upd_q   <= alu_upd;
            carry_q <= alu_carry;
            taken_q <= alu_taken;
          end
        end
        ST_WRITE: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          taken_q <= tk_hold_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign carry_o     = carry_q;
  assign carry_upd_o = upd_q;
  assign taken_o     = taken_q;
  assign mem_addr_o  = byte_addr;
  assign mem_re_o    = (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_rmw_o   = mem_re_o && op_is_rmw(op_q);
  assign mem_wdata_o = wbyte_q;

  assert_single_bit_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_wdata_o ^ rbyte_q) <= 1));

  assert_write_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  assert_jsetclr_wb_taken_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (op_q == OP_JSETCLR)) |=> taken_o);

  assert_rmw_in_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rmw_o |-> mem_re_o);

  assert_busy_holds_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(op_q));

  assert_flags_with_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_upd_o || taken_o) |-> done_o);

endmodule

// File: tb/tb_bool_bit_unit.sv
module tb_bool_bit_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       start, cin;
  logic [3:0] op;
  logic [7:0] baddr;
  logic       busy, done, cout, cupd, taken;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic       mem_re, mem_rmw, mem_we;

  logic [7:0] ram  [0:255];
  logic [7:0] gold [0:255];
  logic [7:0] pin_p0;

  int checks = 0, fails = 0, cyc = 0;
  int re_cnt = 0, we_cnt = 0;

  typedef struct {
    int         t0;
    int         lat;
    logic       upd;
    logic       c;
    logic       tk;
    int         re;
    int         we;
    logic [7:0] caddr;
    logic [7:0] cval;
    string      tag;
  } exp_t;
  exp_t sb[$];

  bool_bit_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .bit_addr_i(baddr),
    .carry_i(cin), .busy_o(busy), .done_o(done), .carry_o(cout), .carry_upd_o(cupd),
    .taken_o(taken), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_rmw_o(mem_rmw),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // port register at 0x80: pins unless the read is for modify
  assign mem_rdata = ((mem_addr == 8'h80) && !mem_rmw) ? pin_p0 : ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re) re_cnt++;
      if (mem_we) we_cnt++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc - e.t0 == e.lat, e.tag, "latency", cyc - e.t0, e.lat);
          chk(cupd == e.upd, "R12", "carry_upd", cupd, e.upd);
          if (e.upd) chk(cout == e.c, e.tag, "carry", cout, e.c);
          chk(taken == e.tk, e.tag, "taken", taken, e.tk);
          chk(re_cnt == e.re, e.tag, "read cycles", re_cnt, e.re);
          chk(we_cnt == e.we, e.tag, "write cycles", we_cnt, e.we);
          chk(ram[e.caddr] == e.cval, e.tag, "byte", ram[e.caddr], e.cval);
        end
        re_cnt = 0;
        we_cnt = 0;
      end
    end
  end

  // driver: model the op independently, push expectation, then drive it
  task automatic issue(input int o, input logic [7:0] a, input logic c, input string tag);
    exp_t e;
    logic [7:0] b, v, nb;
    int i;
    logic bv, rmw;
    b   = (a < 8'd128) ? 8'(32 + a / 8) : 8'(a - a % 8);
    i   = a % 8;
    rmw = (o == 3) || (o == 4) || (o == 5) || (o == 11) || (o == 14);
    v   = ((b == 8'h80) && !rmw) ? pin_p0 : gold[b];
    bv  = v[i];
    nb  = gold[b];
    e.upd = 0; e.c = 0; e.tk = 0; e.we = 0; e.re = 1; e.lat = 2;
    case (o)
      0, 1, 2, 15: begin
        e.re = 0; e.lat = 1;
        if (o != 15) begin e.upd = 1; e.c = (o == 0) ? 1'b1 : (o == 1) ? 1'b0 : !c; end
      end
      3:  nb[i] = 1'b1;
      4:  nb[i] = 1'b0;
      5:  nb[i] = !v[i];
      11: nb[i] = c;
      6:  begin e.upd = 1; e.c = c && bv;  end
      7:  begin e.upd = 1; e.c = c && !bv; end
      8:  begin e.upd = 1; e.c = c || bv;  end
      9:  begin e.upd = 1; e.c = c || !bv; end
      10: begin e.upd = 1; e.c = bv; end
      12: e.tk = bv;
      13: e.tk = !bv;
      14: begin e.tk = bv; if (bv) nb[i] = 1'b0; end
      default: ;
    endcase
    if ((o >= 3 && o <= 5) || o == 11 || (o == 14 && bv)) begin
      e.we = 1; e.lat = 3;
    end
    gold[b] = nb;
    e.caddr = (e.re != 0) ? b : 8'h20;
    e.cval  = gold[e.caddr];
    e.tag   = tag;
    while (busy) @(negedge clk);
    e.t0 = cyc;
    sb.push_back(e);
    start = 1'b1; op = 4'(o); baddr = a; cin = c;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    start = 0; op = 0; baddr = 0; cin = 0; rst_n = 0;
    pin_p0 = 8'h55;
    for (int k = 0; k < 256; k++) begin
      ram[k]  = 8'(k * 37 + 5);
      gold[k] = 8'(k * 37 + 5);
    end
    ram[8'h80]  = 8'hAA;
    gold[8'h80] = 8'hAA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !cupd && !taken, "R1", "status idle", {busy, done, cupd, taken}, 0);
    chk(!mem_re && !mem_we && !mem_rmw, "R1", "memory idle", {mem_re, mem_we, mem_rmw}, 0);

    // R4 carry-only ops, back to back
    issue(0, 8'h00, 1'b0, "R4");
    issue(1, 8'h00, 1'b1, "R4");
    issue(2, 8'h00, 1'b0, "R4");
    issue(2, 8'h00, 1'b1, "R4");
    issue(15, 8'h00, 1'b1, "R4");

    // R2 low-half folding with set/clear/invert
    issue(3, 8'h17, 1'b0, "R2");
    issue(10, 8'h17, 1'b0, "R2");
    issue(4, 8'h7F, 1'b1, "R2");
    issue(5, 8'h00, 1'b0, "R2");
    issue(5, 8'h00, 1'b0, "R2");

    // R3 SFR folding
    issue(3, 8'hD3, 1'b0, "R3");
    issue(4, 8'hF7, 1'b0, "R3");
    issue(10, 8'hD3, 1'b0, "R3");

    // R5 store carry into bit
    issue(11, 8'h42, 1'b1, "R5");
    issue(11, 8'h42, 1'b0, "R5");
    issue(11, 8'hE5, 1'b1, "R5");

    // R6 AND/OR direct and inverted, both carry values
    for (int c = 0; c < 2; c++) begin
      issue(6, 8'h17, c[0], "R6");
      issue(7, 8'h17, c[0], "R6");
      issue(8, 8'h7F, c[0], "R6");
      issue(9, 8'h7F, c[0], "R6");
    end

    // R7 load bit into carry
    issue(10, 8'h23, 1'b1, "R7");
    issue(10, 8'h7F, 1'b1, "R7");

    // R8 bit-test jumps on a set and a clear bit
    issue(12, 8'h17, 1'b0, "R8");
    issue(12, 8'h7F, 1'b0, "R8");
    issue(13, 8'h17, 1'b0, "R8");
    issue(13, 8'h7F, 1'b0, "R8");

    // R9 test-and-clear
    issue(14, 8'h17, 1'b0, "R9");
    issue(14, 8'h17, 1'b0, "R9");

    // R10 port bit: latch 0xAA vs pins 0x55
    issue(10, 8'h81, 1'b0, "R10");
    issue(5, 8'h81, 1'b0, "R10");
    issue(5, 8'h82, 1'b0, "R10");
    issue(14, 8'h83, 1'b0, "R10");

    // R11 start while busy is ignored
    issue(3, 8'h60, 1'b0, "R11");
    @(negedge clk);
    start = 1'b1; op = 4'd3; baddr = 8'h08;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(ram[8'h21] == gold[8'h21], "R11", "intruder byte", ram[8'h21], gold[8'h21]);
    chk(!done && !busy, "R11", "no extra run", {done, busy}, 0);

    wait_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule